// File: doc/BRIEF.md
# Symbol-Lane SPI Write Transmitter

This block is a transmit-only SPI master. It does not produce its serial clock with a divider. Each accepted payload word is expanded into a stream of two-bit symbols. One lane of each symbol is the clock level and the other lane is the data level. A single shifter then plays the symbols out at a fixed symbol rate. The clock lane lives in the same shift register as the data, so the two can never drift apart. A clock edge can only appear where the encoding puts one.

Every payload bit takes two symbols. The first symbol drives the clock low and the second drives it high, and both carry the same data level. The serial clock therefore runs at half the symbol rate, with data launched while the clock is low (mode 0).

The encoded word is kept in a holding register, so one word can be replayed as many times as a 16-bit repeat count asks. Long fills, such as painting a display area with one colour, pay for the encoding only once.

A transfer begins with a start pulse, which captures the repeat count. Words then arrive over a valid/ready handshake. Words that are offered at the exact end of the previous word's final repetition continue the clock with no gap. The transfer closes when no further word is waiting.

Top module: `symlane_spi_tx`

## Requirements
- R1: After reset, and at all times while `cs_n` is 1, `sclk` and `mosi` are both 0.
- R2: A `start` pulse while idle captures `rep_count` and raises `in_ready`. The first word is taken on the first cycle with `in_valid` and `in_ready` both 1.
- R3: Each word is sent most significant bit first. Every bit occupies two symbols of SYM_CYC clock cycles each: `sclk` is low for the first symbol and high for the second. `mosi` is sampled on the rising edge.
- R4: `mosi` changes only together with the falling edge of `sclk` or while `sclk` is low. It is constant for as long as `sclk` is high.
- R5: `cs_n` falls one symbol before the first clock symbol, so the first `sclk` rise comes exactly 2*SYM_CYC cycles after `cs_n` falls.
- R6: `cs_n` rises exactly SYM_CYC cycles after the last falling edge of `sclk`, with no extra or partial clock pulse.
- R7: Each accepted word is sent `rep_count`+1 times. A `rep_count` of 0 sends it once. The count is 16 bits wide.
- R8: A word offered when the final repetition of the current word ends is accepted in that cycle, and the rising edges of `sclk` keep their 2*SYM_CYC spacing across the word boundary.
- R9: A `start` pulse during a running transfer is ignored and does not change the repeat count in use.
- R10: `in_valid` while idle without a `start` is not accepted (`in_ready` stays 0) and produces no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a transfer and captures `rep_count` when idle |
| rep_count | input | REP_W | Extra sends per word (0 means one send) |
| in_data | input | WORD_W | Payload word |
| in_valid | input | 1 | Payload word is offered |
| in_ready | output | 1 | Payload word is taken this cycle when `in_valid` is 1 |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two actions can fall in the same cycle: the end of the last repetition of one word, and the acceptance and loading of the next word from the stream. The bench provokes this by keeping the following word valid long before the current one finishes. This is done with single sends and with repeated sends. The bench judges the result by requiring the serial clock rises to stay exactly 2*SYM_CYC cycles apart through each boundary, with every sampled bit matching the scoreboard. A second coincidence is a start pulse arriving mid-transfer. It must leave the repeat count untouched, which the bench judges from the total number of bits and their order.

// File: rtl/symlane_pkg.sv
package symlane_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_LEAD,
    PH_RUN,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/sym_encoder.sv
module sym_encoder #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0]   word,
  output logic [2*WORD_W-1:0] clk_lane,
  output logic [2*WORD_W-1:0] dat_lane
);
  localparam int SYM_N = 2 * WORD_W;

  // Symbol SYM_N-1 plays first. Bit i (MSB first) maps to a low-clock
  // symbol followed by a high-clock symbol, both carrying the data level.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign clk_lane[SYM_N-1-2*i] = 1'b0;
    assign clk_lane[SYM_N-2-2*i] = 1'b1;
    assign dat_lane[SYM_N-1-2*i] = word[WORD_W-1-i];
    assign dat_lane[SYM_N-2-2*i] = word[WORD_W-1-i];
  end
endmodule

// File: rtl/sym_tick.sv
module sym_tick #(
  parameter int SYM_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  if (SYM_CYC == 1) begin : g_direct
    assign tick = run;
  end else begin : g_div
    localparam int DIV_W = $clog2(SYM_CYC);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == DIV_W'(SYM_CYC - 1));

    always_ff @(posedge clk) begin
      if (rst || !run) cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end

    // R3: symbol length never exceeds SYM_CYC cycles
    assert_div_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= DIV_W'(SYM_CYC - 1));
  end
endmodule

// File: rtl/sym_rep_counter.sv
module sym_rep_counter #(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [REP_W-1:0] ld_val,
  input  logic             dec,
  output logic             zero
);
  logic [REP_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)      left <= '0;
    else if (ld)  left <= ld_val;
    else if (dec) left <= left - 1'b1;
  end

  assign zero = (left == '0);

  // R7: a replay is never requested once the count is spent
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
  // R7: a fresh load and a replay never coincide
  assert_no_ld_dec_R7: assert property (@(posedge clk) disable iff (rst)
    !(ld && dec));
endmodule

// File: rtl/sym_shifter.sv
module sym_shifter #(
  parameter int SYM_N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic             shift,
  input  logic [SYM_N-1:0] ld_clk,
  input  logic [SYM_N-1:0] ld_dat,
  output logic             head_clk,
  output logic             head_dat
);
  logic [SYM_N-1:0] sh_clk;
  logic [SYM_N-1:0] sh_dat;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_clk <= '0;
      sh_dat <= '0;
    end else if (ld) begin
      sh_clk <= ld_clk;
      sh_dat <= ld_dat;
    end else if (shift) begin
      sh_clk <= {sh_clk[SYM_N-2:0], 1'b0};
      sh_dat <= {sh_dat[SYM_N-2:0], 1'b0};
    end
  end

  assign head_clk = sh_clk[SYM_N-1];
  assign head_dat = sh_dat[SYM_N-1];
endmodule

// File: rtl/symlane_spi_tx.sv
module symlane_spi_tx
  import symlane_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int REP_W   = 16,
  parameter int SYM_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [REP_W-1:0]  rep_count,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  localparam int SYM_N = 2 * WORD_W;
  localparam int IDX_W = $clog2(SYM_N);

  phase_e           st;
  logic             tick;
  logic             run;
  logic [SYM_N-1:0] enc_clk, enc_dat;
  logic [SYM_N-1:0] hold_clk, hold_dat;
  logic [IDX_W-1:0] sym_idx;
  logic [REP_W-1:0] rep_latch;
  logic             rep_zero;
  logic             last_sym, word_end, accept;
  logic             sh_ld, sh_shift, sh_clr, take_new;
  logic [SYM_N-1:0] ld_clk, ld_dat;

  sym_encoder #(.WORD_W(WORD_W)) enc_i (
    .word(in_data), .clk_lane(enc_clk), .dat_lane(enc_dat)
  );

  assign run = (st == PH_LEAD) || (st == PH_RUN) || (st == PH_TAIL);

  sym_tick #(.SYM_CYC(SYM_CYC)) tick_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  assign last_sym = (sym_idx == IDX_W'(SYM_N - 1));
  assign word_end = (st == PH_RUN) && tick && last_sym;
  assign in_ready = (st == PH_ARM) || (word_end && rep_zero);
  assign accept   = in_valid && in_ready;

  sym_rep_counter #(.REP_W(REP_W)) rep_i (
    .clk(clk), .rst(rst), .ld(accept), .ld_val(rep_latch),
    .dec(word_end && !rep_zero), .zero(rep_zero)
  );

  always_comb begin
    take_new = word_end && rep_zero && in_valid;
    sh_ld    = ((st == PH_LEAD) && tick) || (word_end && (!rep_zero || in_valid));
    sh_shift = (st == PH_RUN) && tick && !last_sym;
    sh_clr   = word_end && rep_zero && !in_valid;
    ld_clk   = take_new ? enc_clk : hold_clk;
    ld_dat   = take_new ? enc_dat : hold_dat;
  end

  sym_shifter #(.SYM_N(SYM_N)) shf_i (
    .clk(clk), .rst(rst), .clr(sh_clr), .ld(sh_ld), .shift(sh_shift),
    .ld_clk(ld_clk), .ld_dat(ld_dat), .head_clk(sclk), .head_dat(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      cs_n      <= 1'b1;
      sym_idx   <= '0;
      rep_latch <= '0;
      hold_clk  <= '0;
      hold_dat  <= '0;
    end else begin
      if (accept) begin
        hold_clk <= enc_clk;
        hold_dat <= enc_dat;
      end
      unique case (st)
        PH_IDLE: if (start) begin
          rep_latch <= rep_count;
          st        <= PH_ARM;
        end
        PH_ARM: if (accept) begin
          cs_n <= 1'b0;
          st   <= PH_LEAD;
        end
        PH_LEAD: if (tick) begin
          sym_idx <= '0;
          st      <= PH_RUN;
        end
        PH_RUN: if (tick) begin
          sym_idx <= last_sym ? '0 : sym_idx + 1'b1;
          if (sh_clr) st <= PH_TAIL;
        end
        PH_TAIL: if (tick) begin
          cs_n <= 1'b1;
          st   <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R1: deselected lines stay quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sclk && !mosi));
  // R4: data held while the clock is high
  assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R5: lead symbol is selected with the clock low
  assert_lead_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (st == PH_LEAD) |-> (!cs_n && !sclk));
  // R6: deselect happens only with the clock low
  assert_cs_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));
  // R8: a word is taken only when armed or on a final high symbol
  assert_ready_window_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (cs_n || sclk));
  // R9: start during a transfer leaves the repeat count alone
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (start && (st != PH_IDLE)) |=> $stable(rep_latch));
endmodule

// File: tb/symlane_spi_tx_tb_top.sv
module symlane_spi_tx_tb_top;
  localparam int W = 8;
  localparam int S = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [15:0]  rep_count = '0;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready, sclk, mosi, cs_n;

  symlane_spi_tx #(.WORD_W(W), .REP_W(16), .SYM_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rep_count(rep_count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  int  cyc = 0;
  int  rise_cnt = 0;
  bit  done = 1'b0;
  bit  exp_q[$];
  logic [W-1:0] wq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Monitor / scoreboard consumer
  bit p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0, first_rise = 1'b0;
  int t_csfall = 0, t_rise = 0, t_fall = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n)
        chk(!sclk && !mosi, "R1 idle lines", {sclk, mosi}, 0);
      if (p_cs && !cs_n) begin
        t_csfall   = cyc;
        first_rise = 1'b1;
      end
      if (!p_sclk && sclk) begin
        bit e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : ~mosi;
        chk(mosi == e, "R3 bit value on rise", mosi, e);
        if (first_rise) begin
          chk(cyc - t_csfall == 2*S, "R5 select lead", cyc - t_csfall, 2*S);
          first_rise = 1'b0;
        end else begin
          chk(cyc - t_rise == 2*S, "R8 rise spacing", cyc - t_rise, 2*S);
        end
        t_rise = cyc;
        rise_cnt++;
      end
      if (p_sclk && sclk)
        chk(mosi == p_mosi, "R4 data stable while high", mosi, p_mosi);
      if (p_sclk && !sclk) begin
        chk(cyc - t_rise == S, "R3 high width", cyc - t_rise, S);
        t_fall = cyc;
      end
      if (!p_cs && cs_n)
        chk(cyc - t_fall == S, "R6 select trail", cyc - t_fall, S);
      p_cs   = cs_n;
      p_sclk = sclk;
      p_mosi = mosi;
    end
  end

  // Driver: pushes expected bits as each word is taken
  task automatic run_xfer(input logic [15:0] rep, input bit poke, input string tag);
    int nw;
    nw = wq.size();
    rise_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    rep_count = rep;
    @(negedge clk);
    start = 1'b0;
    rep_count = 16'h0;
    chk(in_ready == 1'b1, {"R2 armed ready ", tag}, in_ready, 1);
    for (int i = 0; i < nw; i++) begin
      in_valid = 1'b1;
      in_data  = wq[i];
      while (!in_ready) @(negedge clk);
      for (int r = 0; r <= int'(rep); r++)
        for (int b = W - 1; b >= 0; b--)
          exp_q.push_back(wq[i][b]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (poke) begin
      start = 1'b1;
      rep_count = 16'd7;
      @(negedge clk);
      start = 1'b0;
      rep_count = 16'h0;
    end
    wait (cs_n == 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {"R7 all bits sent ", tag}, exp_q.size(), 0);
    chk(rise_cnt == nw * (int'(rep) + 1) * W, {"R7 clock count ", tag},
        rise_cnt, nw * (int'(rep) + 1) * W);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);

    // R10: valid data with no start is not taken
    rise_cnt = 0;
    in_valid = 1'b1;
    in_data  = 8'hF0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R10 no ready without start", in_ready, 0);
      chk(cs_n == 1'b1, "R10 stays deselected", cs_n, 1);
    end
    in_valid = 1'b0;
    chk(rise_cnt == 0, "R10 no clock", rise_cnt, 0);

    wq = '{8'hA5};
    run_xfer(16'd0, 1'b0, "single");
    wq = '{8'h3C, 8'hFF, 8'h00, 8'h81};
    run_xfer(16'd0, 1'b0, "back-to-back R8");
    wq = '{8'h96, 8'h5A};
    run_xfer(16'd3, 1'b0, "repeat R7 R8");
    wq = '{8'h1E};
    run_xfer(16'd2, 1'b1, "start ignored R9");
    wq = '{8'hC3};
    run_xfer(16'd200, 1'b0, "long fill R7");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule